// File: doc/BRIEF.md
# Boundary-Scan Self-Test Engine

This block runs the built-in test operations of a two-byte, 18-bit bidirectional bus device whose boundary register holds 48 cells. A 3-bit opcode picks the operation. On every rising test-clock edge where the run-test instruction is loaded and the TAP controller sits in Run-Test/Idle, the engine updates the data cells once. The operation can sample the inputs and toggle the outputs. It can also reuse the 36 data cells as a pattern generator, a signature compressor, or a pair of 18-bit halves. In the paired form, the input half compresses the pin data and the output half generates patterns or counts.

Cells 17:0 belong to the A-side pins and cells 35:18 belong to the B-side pins. Cells 47:36 are control cells that no operation ever alters. The enables fix which side is the input side, and the operations run only when every byte points the same way. On each falling edge after an active rising edge, the output-side cells are copied into their shadow latches, which drive the device pins. The TAP state machine, instruction decode and serial shift path belong to the surrounding logic.

Top module: `bist_engine`

## Requirements
- R1: While rst_ni is low, every bit of bsr_o and shadow_o is 0.
- R2: When run_instr_i or idle_i is low, a rising edge leaves all 48 cells and all shadow latches unchanged.
- R3: The engine is active only if en_ab_i[k] equals en_ba_ni[k] for each byte k and en_ab_i[0] equals en_ab_i[1]. In any other case (bypass), all cells and shadow latches hold.
- R4: Cells 47:36 and their shadow latches never change after reset, whatever the opcode.
- R5: opcode_i[1:0] = 00 selects sample/toggle, 01 selects 36-bit pattern generation and 10 selects 36-bit signature analysis, for either value of opcode_i[2]. Code 011 selects signature-plus-pattern and 111 selects signature-plus-count.
- R6: In sample/toggle, the input-side cells load the input-side pins and the output-side cells invert.
- R7: On the falling edge after an active rising edge, the output-side shadow latches take the output-side cells. Input-side shadow latches and control shadow latches hold.
- R8: Pattern generation updates cells 35:0 as next = (s >> 1) ^ (s[0] ? 36'h801000000 : 0).
- R9: Signature analysis applies the R8 step and then XORs in {b_pins_i, a_pins_i}, with A in bits 17:0.
- R10: In 011, the input half steps as an 18-bit compressor: next = (h >> 1) ^ (h[0] ? 18'h20400 : 0) ^ input pins. The output half steps with the same polynomial and no data.
- R11: In 111, the input half compresses as in R10 and the output half increments by 1, wrapping from 18'h3FFFF to 0.
- R12: When en_ab_i[0] = 1, the A side (cells 17:0) is the input side and the B side is the output side. When en_ab_i[0] = 0, the roles swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_instr_i | input | 1 | Run-test instruction is loaded |
| idle_i | input | 1 | TAP controller is in Run-Test/Idle |
| opcode_i | input | 3 | Test operation select |
| en_ab_i | input | 2 | Per-byte A-to-B enable, active high |
| en_ba_ni | input | 2 | Per-byte B-to-A enable, active low |
| a_pins_i | input | 18 | A-side pin data |
| b_pins_i | input | 18 | B-side pin data |
| bsr_o | output | 48 | Boundary cell shift elements |
| shadow_o | output | 48 | Boundary cell shadow latches |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- **Opcode MSB.** Codes that differ only in bit 2 must behave alike for the three lower codes. A decoder that looks at the MSB would instead send 101 or 110 into a combined mode.
- **Counter wrap.** An output half of all ones must wrap to zero. A counter that carries into the next half, or that saturates, would show up at once.
- **Direction.** The mode is run in both directions. This exposes a swapped half assignment in the combined and toggle modes.
- **Enable mismatch.** Each kind of mismatch is applied in turn. A weakened agreement test would let cells move while bypass is in force.
- **Shadow half.** The shadow latches are read after every falling edge. A copy of the wrong half, or a copy made during idle cycles, would show up there.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [2:0] {
    M_TOGGLE,
    M_PRPG_FULL,
    M_PSA_FULL,
    M_MIX_PRPG,
    M_MIX_CNT
  } mode_e;
endpackage

// File: rtl/bist_decode.sv
module bist_decode
  import bist_pkg::*;
#(
  parameter int BYTES = 2
) (
  input  logic [2:0]       opcode_i,
  input  logic             run_instr_i,
  input  logic             idle_i,
  input  logic [BYTES-1:0] en_ab_i,
  input  logic [BYTES-1:0] en_ba_ni,
  output logic             active_o,
  output logic             a_to_b_o,
  output mode_e            mode_o
);
  logic [BYTES-1:0] agree;

  for (genvar k = 0; k < BYTES; k++) begin : g_agree
    assign agree[k] = (en_ab_i[k] == en_ba_ni[k]) && (en_ab_i[k] == en_ab_i[0]);
  end

  assign active_o = run_instr_i && idle_i && (&agree);
  assign a_to_b_o = en_ab_i[0];

  always_comb begin
    unique case (opcode_i[1:0])
      2'b00:   mode_o = M_TOGGLE;
      2'b01:   mode_o = M_PRPG_FULL;
      2'b10:   mode_o = M_PSA_FULL;
      default: mode_o = opcode_i[2] ? M_MIX_CNT : M_MIX_PRPG;
    endcase
  end
endmodule

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int         W    = 18,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] next_o
);
  // Galois step, right-shifting
  assign next_o = {1'b0, state_i[W-1:1]} ^ ({W{state_i[0]}} & POLY) ^ data_i;
endmodule

// File: rtl/bist_shadow.sv
module bist_shadow #(
  parameter int HALF_W = 18,
  parameter int BSR_W  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_q_i,
  input  logic              out_is_b_i,
  input  logic [BSR_W-1:0]  cells_i,
  output logic [BSR_W-1:0]  shadow_o
);
  localparam int FULL_W = 2 * HALF_W;

  logic [BSR_W-1:0] shadow_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (act_q_i) begin
      if (out_is_b_i) shadow_q[FULL_W-1:HALF_W] <= cells_i[FULL_W-1:HALF_W];
      else            shadow_q[HALF_W-1:0]      <= cells_i[HALF_W-1:0];
    end
  end

  assign shadow_o = shadow_q;

  // R7: after an active edge the output half of the latches tracks the cells
  p_shadow_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q_i && out_is_b_i |-> shadow_q[FULL_W-1:HALF_W] == cells_i[FULL_W-1:HALF_W]);
  p_shadow_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q_i && !out_is_b_i |-> shadow_q[HALF_W-1:0] == cells_i[HALF_W-1:0]);
  // R4: control latches never move
  p_shadow_ctrl_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(shadow_q[BSR_W-1:FULL_W]));
endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2,
  parameter int CTRL_W = 12,
  parameter logic [2*BYTES*BYTE_W-1:0] POLY_FULL = 36'h801000000,
  parameter logic [BYTES*BYTE_W-1:0]   POLY_HALF = 18'h20400
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              run_instr_i,
  input  logic                              idle_i,
  input  logic [2:0]                        opcode_i,
  input  logic [BYTES-1:0]                  en_ab_i,
  input  logic [BYTES-1:0]                  en_ba_ni,
  input  logic [BYTES*BYTE_W-1:0]           a_pins_i,
  input  logic [BYTES*BYTE_W-1:0]           b_pins_i,
  output logic [2*BYTES*BYTE_W+CTRL_W-1:0]  bsr_o,
  output logic [2*BYTES*BYTE_W+CTRL_W-1:0]  shadow_o
);
  localparam int HALF_W = BYTES * BYTE_W;
  localparam int FULL_W = 2 * HALF_W;
  localparam int BSR_W  = FULL_W + CTRL_W;

  logic             act_w, a_to_b_w;
  mode_e            mode_w;
  logic [BSR_W-1:0] bsr_q;
  logic             act_q, out_is_b_q;

  bist_decode #(.BYTES(BYTES)) u_dec (
    .opcode_i   (opcode_i),
    .run_instr_i(run_instr_i),
    .idle_i     (idle_i),
    .en_ab_i    (en_ab_i),
    .en_ba_ni   (en_ba_ni),
    .active_o   (act_w),
    .a_to_b_o   (a_to_b_w),
    .mode_o     (mode_w)
  );

  logic [HALF_W-1:0] in_cells, out_cells, in_pins;
  logic [HALF_W-1:0] psa_half, prpg_half, nxt_in, nxt_out;
  logic [FULL_W-1:0] full_data, full_step, nxt_full;

  assign in_cells  = a_to_b_w ? bsr_q[HALF_W-1:0]      : bsr_q[FULL_W-1:HALF_W];
  assign out_cells = a_to_b_w ? bsr_q[FULL_W-1:HALF_W] : bsr_q[HALF_W-1:0];
  assign in_pins   = a_to_b_w ? a_pins_i : b_pins_i;
  assign full_data = (mode_w == M_PSA_FULL) ? {b_pins_i, a_pins_i} : '0;

  bist_lfsr #(.W(FULL_W), .POLY(POLY_FULL)) u_full (
    .state_i(bsr_q[FULL_W-1:0]), .data_i(full_data), .next_o(full_step));
  bist_lfsr #(.W(HALF_W), .POLY(POLY_HALF)) u_psa (
    .state_i(in_cells), .data_i(in_pins), .next_o(psa_half));
  bist_lfsr #(.W(HALF_W), .POLY(POLY_HALF)) u_prpg (
    .state_i(out_cells), .data_i('0), .next_o(prpg_half));

  always_comb begin
    nxt_in  = in_cells;
    nxt_out = out_cells;
    unique case (mode_w)
      M_TOGGLE:   begin nxt_in = in_pins;  nxt_out = ~out_cells;            end
      M_MIX_PRPG: begin nxt_in = psa_half; nxt_out = prpg_half;             end
      M_MIX_CNT:  begin nxt_in = psa_half; nxt_out = out_cells + 1'b1;      end
      default:    ;
    endcase
    if (mode_w == M_PRPG_FULL || mode_w == M_PSA_FULL) nxt_full = full_step;
    else nxt_full = a_to_b_w ? {nxt_out, nxt_in} : {nxt_in, nxt_out};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsr_q      <= '0;
      act_q      <= 1'b0;
      out_is_b_q <= 1'b0;
    end else begin
      act_q      <= act_w;
      out_is_b_q <= a_to_b_w;
      if (act_w) bsr_q[FULL_W-1:0] <= nxt_full;
    end
  end

  bist_shadow #(.HALF_W(HALF_W), .BSR_W(BSR_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_q_i   (act_q),
    .out_is_b_i(out_is_b_q),
    .cells_i   (bsr_q),
    .shadow_o  (shadow_o)
  );

  assign bsr_o = bsr_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_instr_i && idle_i) |=> $stable(bsr_q));
  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ab_i[0] != en_ba_ni[0]) || (en_ab_i[0] != en_ab_i[BYTES-1]) |=> $stable(bsr_q));
  p_ctrl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(bsr_q[BSR_W-1:FULL_W]));
  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_w && mode_w == M_TOGGLE && a_to_b_w |=>
      bsr_q[FULL_W-1:HALF_W] == ~$past(bsr_q[FULL_W-1:HALF_W]));
  p_count_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_w && mode_w == M_MIX_CNT && !a_to_b_w |=>
      bsr_q[HALF_W-1:0] == HALF_W'($past(bsr_q[HALF_W-1:0]) + 1'b1));
endmodule

// File: tb/sim_bist_engine.sv
module sim_bist_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_instr_i = 1'b0, idle_i = 1'b0;
  logic [2:0]  opcode_i = '0;
  logic [1:0]  en_ab_i = '0, en_ba_ni = '0;
  logic [17:0] a_pins_i = '0, b_pins_i = '0;
  logic [47:0] bsr_o, shadow_o;

  int n_chk = 0, n_bad = 0;
  logic [47:0] exp_bsr = '0, exp_sh = '0;

  always #4 clk_i = ~clk_i;

  bist_engine u0 (.*);

  function automatic logic [35:0] g36(logic [35:0] s, logic [35:0] d);
    return (s >> 1) ^ (s[0] ? 36'h801000000 : 36'h0) ^ d;
  endfunction

  function automatic logic [17:0] g18(logic [17:0] s, logic [17:0] d);
    return (s >> 1) ^ (s[0] ? 18'h20400 : 18'h0) ^ d;
  endfunction

  function automatic logic [47:0] model(logic [47:0] s, logic [2:0] op, logic a2b,
                                        logic [17:0] a, logic [17:0] b);
    logic [17:0] ic, oc, ip, ni, no;
    logic [35:0] f;
    logic [47:0] r;
    r  = s;
    ic = a2b ? s[17:0] : s[35:18];
    oc = a2b ? s[35:18] : s[17:0];
    ip = a2b ? a : b;
    if (op[1:0] == 2'b01)      f = g36(s[35:0], 36'h0);
    else if (op[1:0] == 2'b10) f = g36(s[35:0], {b, a});
    else begin
      if (op[1:0] == 2'b00) begin ni = ip; no = ~oc; end
      else if (!op[2])      begin ni = g18(ic, ip); no = g18(oc, 18'h0); end
      else                  begin ni = g18(ic, ip); no = oc + 18'd1; end
      f = a2b ? {no, ni} : {ni, no};
    end
    r[35:0] = f;
    return r;
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op[1:0])
      2'b00:   return "R6";
      2'b01:   return "R8";
      2'b10:   return "R9";
      default: return op[2] ? "R11" : "R10";
    endcase
  endfunction

  task automatic check(logic [47:0] got, logic [47:0] exp, string tag, string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(logic [2:0] op, logic run, logic idl, logic [1:0] ab,
                      logic [1:0] ban, logic [17:0] a, logic [17:0] b, string tag);
    logic act;
    opcode_i = op; run_instr_i = run; idle_i = idl;
    en_ab_i = ab; en_ba_ni = ban; a_pins_i = a; b_pins_i = b;
    act = run && idl && (ab[0] == ban[0]) && (ab[1] == ban[1]) && (ab[0] == ab[1]);
    @(posedge clk_i);
    #5;
    if (act) begin
      exp_bsr = model(exp_bsr, op, ab[0], a, b);
      if (ab[0]) exp_sh[35:18] = exp_bsr[35:18];
      else       exp_sh[17:0]  = exp_bsr[17:0];
    end
    check(bsr_o, exp_bsr, tag, "cells");
    check(shadow_o, exp_sh, tag, "shadow");
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int r;
    r = $urandom(32'd2024);
    #20;
    check(bsr_o, 48'h0, "R1", "reset cells");
    check(shadow_o, 48'h0, "R1", "reset shadow");
    @(posedge clk_i); #1; rst_ni = 1'b1; #4;

    // R12 + R6: toggle both directions, seed nonzero state
    step(3'b000, 1, 1, 2'b11, 2'b11, 18'h1A5C3, 18'h0F0F0, "R12");
    step(3'b100, 1, 1, 2'b00, 2'b00, 18'h2B4D1, 18'h35A5A, "R6");
    // R2: not running or not idle
    step(3'b001, 0, 1, 2'b11, 2'b11, 18'h3FFFF, 18'h3FFFF, "R2");
    step(3'b010, 1, 0, 2'b11, 2'b11, 18'h3FFFF, 18'h3FFFF, "R2");
    // R3: each style of enable disagreement
    step(3'b000, 1, 1, 2'b11, 2'b10, 18'h12345, 18'h23456, "R3");
    step(3'b000, 1, 1, 2'b01, 2'b01, 18'h12345, 18'h23456, "R3");
    step(3'b001, 1, 1, 2'b10, 2'b10, 18'h12345, 18'h23456, "R3");
    // R5: MSB ignored on low codes
    step(3'b001, 1, 1, 2'b11, 2'b11, 18'h0, 18'h0, "R8");
    step(3'b101, 1, 1, 2'b11, 2'b11, 18'h0, 18'h0, "R5");
    step(3'b010, 1, 1, 2'b00, 2'b00, 18'h0ABCD, 18'h31337, "R9");
    step(3'b110, 1, 1, 2'b00, 2'b00, 18'h1DEAD, 18'h0BEEF, "R5");
    step(3'b100, 1, 1, 2'b11, 2'b11, 18'h00FF0, 18'h3F00F, "R5");
    step(3'b011, 1, 1, 2'b11, 2'b11, 18'h15555, 18'h2AAAA, "R10");
    step(3'b011, 1, 1, 2'b00, 2'b00, 18'h15555, 18'h2AAAA, "R10");
    // R11: counter wrap, B half loaded with all ones as input side
    step(3'b000, 1, 1, 2'b00, 2'b00, 18'h0, 18'h3FFFF, "R6");
    step(3'b111, 1, 1, 2'b11, 2'b11, 18'h00001, 18'h0, "R11");
    step(3'b111, 1, 1, 2'b11, 2'b11, 18'h00002, 18'h0, "R11");
    step(3'b111, 1, 1, 2'b00, 2'b00, 18'h0, 18'h00003, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] op; logic run, idl; logic [1:0] ab, ban; string tag;
      op = 3'($urandom());
      run = ($urandom() % 10) != 0;
      idl = ($urandom() % 10) != 0;
      ab  = ($urandom() % 2) ? 2'b11 : 2'b00;
      ban = ab;
      if (($urandom() % 5) == 0) begin
        ab  = 2'($urandom());
        ban = 2'($urandom());
      end
      tag = op_tag(op);
      if (!(run && idl)) tag = "R2";
      else if (!(ab == ban && ab[0] == ab[1])) tag = "R3";
      step(op, run, idl, ab, ban, 18'($urandom()), 18'($urandom()), tag);
      if ((i % 50) == 0) begin
        check({36'h0, bsr_o[47:36]}, 48'h0, "R4", "control cells");
        check({36'h0, shadow_o[47:36]}, 48'h0, "R7", "control shadow");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule